// File: doc/BRIEF.md
# Bitfield-Capable 32-bit ALU

This is a purely combinational execution unit for a 32-bit integer datapath. One operand (A) always comes from a register. The second operand (B) is taken from an 11-bit operand field. When the top bit of that field is set, B is a 10-bit signed immediate. When the top bit is clear, the low five bits of the field name a register. The block drives that register index out to the register file's read port and takes back the data that is read.

A 4-bit function code selects the operation. The simple operations are add, subtract, the four bitwise logic operations, shifts and rotate. The richer operations are:

- Bitfield insert and bitfield extract, signed or unsigned. The field position and length are packed into the low bits of B.
- An operation that shifts A left by ten places and fills the vacated bits from the bottom of B.
- A five-stage bit permutation. Each bit of B enables one swap stage.

The one unassigned code raises an illegal-operation flag. The result settles in the same cycle as the inputs.

Top module: `bfalu_top`

## Requirements
- R1: When opd_field[10] is 1, B is opd_field[9:0] sign-extended to 32 bits. When it is 0, B is rf_rdata. rf_raddr always equals opd_field[4:0].
- R2: Code 0 gives A+B and code 2 gives A-B, both modulo 2^32.
- R3: Code 4 gives A AND B, code 5 gives A OR B, code 6 gives A XOR B and code 7 gives NOT(A XOR B).
- R4: Code 1 rotates A right by B[4:0] places. The higher bits of B are ignored.
- R5: Code 8 shifts A left and code 9 shifts A right logically, each by the full unsigned value of B. Any amount of 32 or more gives 0.
- R6: Code 10 (hex A) shifts A right arithmetically by the unsigned value of B. Any amount of 32 or more gives 32 copies of A[31].
- R7: Code 3 gives (A shifted left by 10) OR B[9:0].
- R8: For the bitfield codes (11, 12, 13), the position is B[4:0] and the length is B[8:5]. A length field of 0 means a length of 16.
- R9: Code 11 (hex B) replaces the length-bit field of A that starts at the position with the low bits of (B logically shifted right by 10). Field bits that would land above bit 31 are dropped. All other bits of A are kept.
- R10: Code 13 (hex D) gives (A logically shifted right by the position), masked to its low length bits and zero-extended.
- R11: Code 12 (hex C) gives the same field as code 13, sign-extended from its bit length-1.
- R12: Code 14 (hex E) applies five swap stages in order, each enabled by one bit of B:
  - B[0] swaps adjacent bits.
  - B[1] swaps 2-bit pairs.
  - B[2] swaps nibbles.
  - B[3] swaps bytes within each halfword.
  - B[4] swaps the two halfwords.
- R13: Code 15 (hex F) sets illegal to 1 and drives result to 0. Every other code drives illegal to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opd_a | input | 32 | Operand A, a register value |
| opd_field | input | 11 | Operand-B field: immediate-select flag in bit 10, immediate or register index below it |
| rf_rdata | input | 32 | Register file data for the index on rf_raddr |
| func | input | 4 | Function code |
| rf_raddr | output | 5 | Register index presented to the register file |
| result | output | 32 | Operation result |
| illegal | output | 1 | High for the unassigned function code |

## Verification
The block holds no state, so a wrong internal value shows at result in the same cycle. It is confined to the function codes that use the faulty piece of logic. A bad operand-select path corrupts every code at once. A mis-built swap stage, mask or length decode shows only under that code, and only for the B values that enable the stage or reach the broken length or position. For that reason the sweep covers every code with the full range of lengths, positions that run past bit 31, zero-length fields, and shift amounts at and above 32.

// File: rtl/bfalu_pkg.sv
// Package: shared function-code encoding for the bitfield ALU.
// Assumes a 4-bit function code; every one of the 16 values is named.
package bfalu_pkg;

    typedef enum logic [3:0] {
        FN_ADD    = 4'h0,
        FN_ROR    = 4'h1,
        FN_SUB    = 4'h2,
        FN_APPEND = 4'h3,
        FN_AND    = 4'h4,
        FN_OR     = 4'h5,
        FN_XOR    = 4'h6,
        FN_XNOR   = 4'h7,
        FN_SHL    = 4'h8,
        FN_SHR    = 4'h9,
        FN_SAR    = 4'hA,
        FN_BINS   = 4'hB,
        FN_XTRS   = 4'hC,
        FN_XTRU   = 4'hD,
        FN_PERM   = 4'hE,
        FN_BAD    = 4'hF
    } alu_fn_e;

endpackage

// File: rtl/bfalu_opsel.sv
// Module: bfalu_opsel
// Builds operand B from the operand field. The top field bit picks a
// sign-extended immediate or the register named by the low index bits.
// Assumes the register file answers rf_raddr combinationally on rf_rdata.
module bfalu_opsel #(
    parameter int DATA_W  = 32,
    parameter int FIELD_W = 11,
    parameter int IMM_W   = 10,
    parameter int RIDX_W  = 5
) (
    input  logic [FIELD_W-1:0] field,
    input  logic [DATA_W-1:0]  rf_rdata,
    output logic [RIDX_W-1:0]  rf_raddr,
    output logic [DATA_W-1:0]  op_b
);

    localparam int EXT_W = DATA_W - IMM_W;

    logic             use_imm;
    logic [IMM_W-1:0] imm;

    assign use_imm  = field[FIELD_W-1];
    assign imm      = field[IMM_W-1:0];
    assign rf_raddr = field[RIDX_W-1:0];

    // Choose between the sign-extended immediate and the register value.
    always_comb begin
        if (use_imm) op_b = {{EXT_W{imm[IMM_W-1]}}, imm};
        else         op_b = rf_rdata;
    end

endmodule

// File: rtl/bfalu_shift.sv
// Module: bfalu_shift
// Rotate right by the low amount bits; logical and arithmetic shifts by
// the whole of B. Amounts that reach DATA_W saturate to zero or to sign fill.
// Assumes DATA_W is a power of two.
module bfalu_shift #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] rot,
    output logic [DATA_W-1:0] shl,
    output logic [DATA_W-1:0] shr,
    output logic [DATA_W-1:0] sar
);

    localparam int AMT_W = $clog2(DATA_W);

    logic [AMT_W-1:0]    amt;
    logic                oversize;
    logic [2*DATA_W-1:0] doubled;

    assign amt      = b[AMT_W-1:0];
    assign oversize = |b[DATA_W-1:AMT_W];

    // Rotate by shifting a doubled copy of A and keeping its low half.
    always_comb begin
        doubled = {a, a} >> amt;
        rot     = doubled[DATA_W-1:0];
    end

    // Shifts with saturation for amounts at or above the word width.
    always_comb begin
        if (oversize) begin
            shl = '0;
            shr = '0;
            sar = {DATA_W{a[DATA_W-1]}};
        end else begin
            shl = a << amt;
            shr = a >> amt;
            sar = DATA_W'($signed(a) >>> amt);
        end
    end

endmodule

// File: rtl/bfalu_bitfield.sv
// Module: bfalu_bitfield
// Bitfield insert and signed or unsigned extract. The position sits in the
// low bits of B and the length just above it; a zero length field means
// the maximum length, 2**LEN_W. Insert data is B shifted right by IMM_W.
// Assumes 2**LEN_W is below DATA_W.
module bfalu_bitfield #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 10,
    parameter int LEN_W  = 4
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] ins,
    output logic [DATA_W-1:0] xtr_u,
    output logic [DATA_W-1:0] xtr_s
);

    localparam int POS_W = $clog2(DATA_W);

    logic [POS_W-1:0]  pos;
    logic [LEN_W-1:0]  len_code;
    logic [LEN_W:0]    len;
    logic [DATA_W-1:0] len_mask;
    logic [DATA_W-1:0] top_bit;
    logic [DATA_W-1:0] place_mask;
    logic [DATA_W-1:0] ins_src;
    logic [DATA_W-1:0] aligned;
    logic              fld_sign;

    assign pos      = b[POS_W-1:0];
    assign len_code = b[POS_W+LEN_W-1:POS_W];

    // Decode the length field, mapping zero to the largest length.
    always_comb begin
        if (len_code == '0) len = (LEN_W+1)'(1) << LEN_W;
        else                len = {1'b0, len_code};
    end

    // Build the field mask, its most significant bit and its placed copy.
    always_comb begin
        len_mask   = ~({DATA_W{1'b1}} << len);
        top_bit    = len_mask ^ (len_mask >> 1);
        place_mask = len_mask << pos;
    end

    // Insert: keep A outside the placed mask, take shifted B data inside it.
    always_comb begin
        ins_src = b >> IMM_W;
        ins     = (a & ~place_mask) | ((ins_src << pos) & place_mask);
    end

    // Extract: align the field to bit 0, then zero- or sign-extend it.
    always_comb begin
        aligned  = a >> pos;
        xtr_u    = aligned & len_mask;
        fld_sign = |(aligned & top_bit);
        xtr_s    = fld_sign ? (xtr_u | ~len_mask) : xtr_u;
    end

endmodule

// File: rtl/bfalu_permute.sv
// Module: bfalu_permute
// Staged conditional swap network. Stage k exchanges neighbouring blocks of
// 2**k bits when ctl[k] is set; stages are applied from k=0 upward.
// Assumes DATA_W is a power of two.
module bfalu_permute #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0]          a,
    input  logic [$clog2(DATA_W)-1:0]  ctl,
    output logic [DATA_W-1:0]          y
);

    localparam int STAGES = $clog2(DATA_W);

    // Mask of the bits that sit in the lower block of each 2**k-bit pair.
    function automatic logic [DATA_W-1:0] lower_blocks(input int k);
        logic [DATA_W-1:0] m;
        for (int i = 0; i < DATA_W; i++) m[i] = ((i >> k) & 1) == 0;
        return m;
    endfunction

    logic [DATA_W-1:0] stage_val [0:STAGES];

    assign stage_val[0] = a;

    generate
        for (genvar k = 0; k < STAGES; k++) begin : g_stage
            localparam int                SPAN = 1 << k;
            localparam logic [DATA_W-1:0] LO   = lower_blocks(k);
            logic [DATA_W-1:0] swapped;
            // Swap neighbouring blocks of this stage's span.
            always_comb begin
                swapped = ((stage_val[k] & LO) << SPAN) | ((stage_val[k] & ~LO) >> SPAN);
            end
            assign stage_val[k+1] = ctl[k] ? swapped : stage_val[k];
        end
    endgenerate

    assign y = stage_val[STAGES];

endmodule

// File: rtl/bfalu_top.sv
// Module: bfalu_top
// Combinational ALU. Operand B comes from an immediate or from the register
// file, and a 4-bit function code picks arithmetic, logic, shift, rotate,
// append, bitfield or permutation. The unassigned code raises illegal and
// forces the result to zero. Holds no state, so it needs no clock or reset.
module bfalu_top #(
    parameter int DATA_W  = 32,
    parameter int FIELD_W = 11,
    parameter int IMM_W   = 10,
    parameter int RIDX_W  = 5,
    parameter int LEN_W   = 4
) (
    input  logic [DATA_W-1:0]  opd_a,
    input  logic [FIELD_W-1:0] opd_field,
    input  logic [DATA_W-1:0]  rf_rdata,
    input  logic [3:0]         func,
    output logic [RIDX_W-1:0]  rf_raddr,
    output logic [DATA_W-1:0]  result,
    output logic               illegal
);

    import bfalu_pkg::*;

    localparam int STAGES = $clog2(DATA_W);

    logic [DATA_W-1:0] op_b;
    logic [DATA_W-1:0] rot_v, shl_v, shr_v, sar_v;
    logic [DATA_W-1:0] ins_v, xtru_v, xtrs_v, perm_v;
    logic [DATA_W-1:0] append_v;

    bfalu_opsel #(
        .DATA_W(DATA_W), .FIELD_W(FIELD_W), .IMM_W(IMM_W), .RIDX_W(RIDX_W)
    ) u_opsel (
        .field(opd_field), .rf_rdata(rf_rdata), .rf_raddr(rf_raddr), .op_b(op_b)
    );

    bfalu_shift #(.DATA_W(DATA_W)) u_shift (
        .a(opd_a), .b(op_b), .rot(rot_v), .shl(shl_v), .shr(shr_v), .sar(sar_v)
    );

    bfalu_bitfield #(.DATA_W(DATA_W), .IMM_W(IMM_W), .LEN_W(LEN_W)) u_bitfield (
        .a(opd_a), .b(op_b), .ins(ins_v), .xtr_u(xtru_v), .xtr_s(xtrs_v)
    );

    bfalu_permute #(.DATA_W(DATA_W)) u_permute (
        .a(opd_a), .ctl(op_b[STAGES-1:0]), .y(perm_v)
    );

    assign append_v = {opd_a[DATA_W-IMM_W-1:0], op_b[IMM_W-1:0]};

    // Route the selected operation to the result and flag the unused code.
    always_comb begin
        illegal = 1'b0;
        unique case (alu_fn_e'(func))
            FN_ADD:    result = opd_a + op_b;
            FN_ROR:    result = rot_v;
            FN_SUB:    result = opd_a - op_b;
            FN_APPEND: result = append_v;
            FN_AND:    result = opd_a & op_b;
            FN_OR:     result = opd_a | op_b;
            FN_XOR:    result = opd_a ^ op_b;
            FN_XNOR:   result = ~(opd_a ^ op_b);
            FN_SHL:    result = shl_v;
            FN_SHR:    result = shr_v;
            FN_SAR:    result = sar_v;
            FN_BINS:   result = ins_v;
            FN_XTRS:   result = xtrs_v;
            FN_XTRU:   result = xtru_v;
            FN_PERM:   result = perm_v;
            default: begin
                result  = '0;
                illegal = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/bfalu_checker.sv
// Module: bfalu_checker
// Combinational property checks on the ALU. Each one relates the ports to
// the internally selected operand B. It is attached to bfalu_top by the
// bind below.
module bfalu_checker #(
    parameter int DATA_W  = 32,
    parameter int FIELD_W = 11,
    parameter int RIDX_W  = 5
) (
    input logic [DATA_W-1:0]  opd_a,
    input logic [FIELD_W-1:0] opd_field,
    input logic [DATA_W-1:0]  rf_rdata,
    input logic [3:0]         func,
    input logic [RIDX_W-1:0]  rf_raddr,
    input logic [DATA_W-1:0]  op_b,
    input logic [DATA_W-1:0]  result,
    input logic               illegal
);

    // Check the algebraic and flag relations whenever any input moves.
    always_comb begin
        // R1
        opsel_index_chk: assert (rf_raddr == opd_field[RIDX_W-1:0])
            else $error("register index does not follow the operand field");
        // R1
        opsel_reg_chk: assert (opd_field[FIELD_W-1] || op_b == rf_rdata)
            else $error("register-mode operand B differs from read data");
        // R2
        add_inverse_chk: assert (func != 4'h0 || result - op_b == opd_a)
            else $error("sum minus B does not return A");
        // R3
        xor_inverse_chk: assert (func != 4'h6 || (result ^ op_b) == opd_a)
            else $error("xor result does not undo with B");
        // R6
        sar_sign_chk: assert (func != 4'hA || result[DATA_W-1] == opd_a[DATA_W-1])
            else $error("arithmetic shift lost the sign bit");
        // R10
        xtru_width_chk: assert (func != 4'hD || (result >> 16) == '0)
            else $error("unsigned extract wider than the longest field");
        // R12
        perm_identity_chk: assert (func != 4'hE || op_b[4:0] != 5'd0 || result == opd_a)
            else $error("permutation with no stage enabled changed A");
        // R13
        illegal_flag_chk: assert (illegal == (func == 4'hF))
            else $error("illegal flag does not match the unassigned code");
        // R13
        illegal_zero_chk: assert (!illegal || result == '0)
            else $error("illegal operation left a nonzero result");
    end

endmodule

bind bfalu_top bfalu_checker #(
    .DATA_W(DATA_W), .FIELD_W(FIELD_W), .RIDX_W(RIDX_W)
) u_bfalu_chk (
    .opd_a(opd_a), .opd_field(opd_field), .rf_rdata(rf_rdata), .func(func),
    .rf_raddr(rf_raddr), .op_b(op_b), .result(result), .illegal(illegal)
);

// File: tb/bfalu_top_bench.sv
// Bench: near-exhaustive sweep over every function code. It uses crafted
// corner operands plus pseudo-random vectors, and a bit-level model
// computed directly from the requirements.
module bfalu_top_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] opd_a = '0;
    logic [10:0] opd_field = '0;
    logic [3:0]  func = '0;
    logic [31:0] rf_rdata;
    logic [4:0]  rf_raddr;
    logic [31:0] result;
    logic        illegal;

    logic [31:0] regs [0:31];
    int          n_checks = 0;
    int          n_errors = 0;
    logic [31:0] seed = 32'h1357_9BDF;

    always #10 clk = ~clk;

    assign rf_rdata = regs[rf_raddr];

    bfalu_top u_bfalu_top (
        .opd_a(opd_a), .opd_field(opd_field), .rf_rdata(rf_rdata), .func(func),
        .rf_raddr(rf_raddr), .result(result), .illegal(illegal)
    );

    // Step the xorshift generator and return the new value.
    function automatic logic [31:0] rnd();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed;
    endfunction

    // Expected B per R1.
    function automatic logic [31:0] model_b(input logic [10:0] f);
        logic [31:0] v;
        if (f[10]) begin
            for (int i = 0; i < 32; i++) v[i] = (i < 10) ? f[i] : f[9];
        end else begin
            v = regs[f[4:0]];
        end
        return v;
    endfunction

    // Expected result from the requirements, computed bit by bit.
    function automatic logic [31:0] model(input logic [3:0] f, input logic [31:0] a,
                                          input logic [31:0] b);
        logic [31:0] e, x, y, src;
        int pos, len;
        e = '0;
        pos = int'(b[4:0]);
        len = (b[8:5] == 4'd0) ? 16 : int'(b[8:5]);
        case (f)
            4'h0: e = a + b;
            4'h1: for (int i = 0; i < 32; i++) e[i] = a[(i + pos) % 32];
            4'h2: e = a - b;
            4'h3: e = (a << 10) | (b & 32'h3FF);
            4'h4: e = a & b;
            4'h5: e = a | b;
            4'h6: e = a ^ b;
            4'h7: e = ~(a ^ b);
            4'h8: e = (b >= 32) ? 32'd0 : (a << b);
            4'h9: e = (b >= 32) ? 32'd0 : (a >> b);
            4'hA: for (int i = 0; i < 32; i++)
                      e[i] = (b >= 32 || i + b > 31) ? a[31] : a[i + int'(b[4:0])];
            4'hB: begin
                src = b >> 10;
                for (int i = 0; i < 32; i++)
                    e[i] = (i >= pos && i < pos + len) ? src[i - pos] : a[i];
            end
            4'hC, 4'hD: begin
                for (int i = 0; i < 32; i++)
                    e[i] = (i < len && i + pos < 32) ? a[i + pos] : 1'b0;
                if (f == 4'hC)
                    for (int i = 0; i < 32; i++) if (i >= len) e[i] = e[len - 1];
            end
            4'hE: begin
                x = a;
                for (int k = 0; k < 5; k++) begin
                    if (b[k]) begin
                        for (int i = 0; i < 32; i++) y[i] = x[i ^ (1 << k)];
                        x = y;
                    end
                end
                e = x;
            end
            default: e = '0;
        endcase
        return e;
    endfunction

    // Requirement tag for a function code's main behaviour.
    function automatic string tag_of(input logic [3:0] f, input logic [31:0] b);
        if ((f == 4'hB || f == 4'hC || f == 4'hD) && b[8:5] == 4'd0) return "R8";
        case (f)
            4'h0, 4'h2:             return "R2";
            4'h1:                   return "R4";
            4'h3:                   return "R7";
            4'h4, 4'h5, 4'h6, 4'h7: return "R3";
            4'h8, 4'h9:             return "R5";
            4'hA:                   return "R6";
            4'hB:                   return "R9";
            4'hC:                   return "R11";
            4'hD:                   return "R10";
            4'hE:                   return "R12";
            default:                return "R13";
        endcase
    endfunction

    // Count one comparison and report it if it fails.
    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp,
                         input logic [3:0] f, input logic [31:0] a, input logic [10:0] fld);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s func=%h a=%h field=%h actual=%h expected=%h",
                     tag, f, a, fld, got, exp);
        end
    endtask

    // Drive one vector after a rising edge and check it at the falling edge.
    task automatic run_vec(input logic [3:0] f, input logic [31:0] a, input logic [10:0] fld);
        logic [31:0] b;
        @(posedge clk);
        func = f;
        opd_a = a;
        opd_field = fld;
        @(negedge clk);
        b = model_b(fld);
        check(tag_of(f, b), result, model(f, a, b), f, a, fld);
        check("R13", {31'd0, illegal}, {31'd0, f == 4'hF}, f, a, fld);
        check("R1", {27'd0, rf_raddr}, {27'd0, fld[4:0]}, f, a, fld);
    endtask

    logic [10:0] corner_fld [0:10];
    logic [31:0] corner_a   [0:3];

    initial begin
        corner_fld[0]  = 11'h400;   // immediate 0
        corner_fld[1]  = 11'h41F;   // imm: len 0 (16), pos 31
        corner_fld[2]  = 11'h7FF;   // imm: -1
        corner_fld[3]  = 11'h5E4;   // imm: len 15, pos 4
        corner_fld[4]  = 11'h200;   // imm-flag clear: register 0
        corner_fld[5]  = 11'h001;
        corner_fld[6]  = 11'h002;
        corner_fld[7]  = 11'h003;
        corner_fld[8]  = 11'h004;
        corner_fld[9]  = 11'h005;
        corner_fld[10] = 11'h006;
        corner_a[0] = 32'h0000_0000;
        corner_a[1] = 32'h8000_0001;
        corner_a[2] = 32'hFFFF_FFFF;
        corner_a[3] = 32'h1234_5678;
        for (int i = 0; i < 32; i++) regs[i] = rnd();
        regs[0] = 32'd0;
        regs[1] = 32'd32;           // shift by exactly the width
        regs[2] = 32'd33;
        regs[3] = 32'hFFFF_FFFF;
        regs[4] = 32'h0000_001F;    // len 0, pos 31
        regs[5] = 32'hABCD_E3DC;    // len 14, pos 28, insert data in upper bits
        regs[6] = 32'd31;
        // Reset phase: all-zero inputs give a zero result and no flag.
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R2", result, 32'd0, 4'h0, 32'd0, 11'd0);
        check("R13", {31'd0, illegal}, 32'd0, 4'h0, 32'd0, 11'd0);
        rst_n = 1'b1;
        for (int f = 0; f < 16; f++) begin
            for (int c = 0; c < 11; c++)
                for (int j = 0; j < 4; j++)
                    run_vec(4'(f), corner_a[j], corner_fld[c]);
            for (int n = 0; n < 150; n++)
                run_vec(4'(f), rnd(), 11'(rnd()));
        end
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule